// File: doc/BRIEF.md
# Vertical Linear Interpolating Line Scaler

This block stretches a video frame vertically by a non-integer ratio. Each output pixel is a weighted mix of two neighbouring source lines. By default 378 source lines map onto 600 output lines, with 576 pixels per line and 8 bits per pixel.

Source pixels enter through a write port that carries a line number, a column and a data byte. The lowest bit of the line number selects one of two line banks. The even bank holds the most recent even line and the odd bank holds the most recent odd line. Because the two vertical neighbours always have opposite parity, both are read in the same clock from the same column address.

A fixed-point position register with 8 fractional bits tracks where the current output line falls in source-line units. A frame-start pulse clears it, and each line-advance pulse adds the step. The integer part picks the upper neighbour line. The fraction sets the mix weights, and the bank that holds the upper line receives the inverted fraction.

The surrounding logic must load the pair of lines that the position register currently straddles. Each pixel request then returns one blended byte two clocks later.

Top module: `vlin_scaler`

## Requirements
- R1: While `rst` is high at a clock edge, `pix_valid` goes low after that edge and the position register is cleared to 0.
- R2: A write with `wr_en` high stores `wr_data` at column `wr_x` in the even bank when `wr_line[0]` is 0, and in the odd bank when it is 1. A read presented in the same cycle as a write to the same bank and column returns the old content.
- R3: `frame_start` clears the position at the next edge and takes priority over `line_adv`. Otherwise `line_adv` adds STEP = floor(378*256/600) = 161 to the position. With neither pulse, the position holds.
- R4: The upper neighbour line U is the position shifted right by 8 bits, and the fraction F is the low 8 bits of the position. `pix_upper` reports U for each returned pixel.
- R5: Let E and O be the even-bank and odd-bank pixels at `rd_x`. When U is even, the pixel is (E*(255-F) + O*F) >> 8. When U is odd, the pixel is (O*(255-F) + E*F) >> 8. The result is clamped to 255.
- R6: When U is 377 (the last source line) or larger, U is reported as 377. Both products then use the pixel P from the bank of U's parity, so the result is (P*255) >> 8 for any fraction.
- R7: A request with `rd_en` high raises `pix_valid`, together with its `pix_data` and `pix_upper`, exactly two clock edges later. A cycle with `rd_en` low gives `pix_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Source pixel write strobe |
| wr_line | input | 9 | Source line number; bit 0 selects the bank |
| wr_x | input | 10 | Source column |
| wr_data | input | 8 | Source pixel |
| frame_start | input | 1 | Clear the output line position |
| line_adv | input | 1 | Advance the position by one output line |
| rd_en | input | 1 | Output pixel request |
| rd_x | input | 10 | Requested column |
| pix_valid | output | 1 | Blended pixel valid |
| pix_data | output | 8 | Blended pixel |
| pix_upper | output | 9 | Upper neighbour line used for this pixel |

## Verification
A pixel request is due at the outputs after the second rising edge following the cycle in which `rd_en` is presented. Its weights come from the position held during the request cycle. A position pulse therefore affects only the requests made after its edge. A write becomes visible to a request made in the cycle after the write's edge.

The bench drives on falling edges. A behavioural model updates on rising edges: it first evaluates the request against the old memory and position, then applies the write and the pulse, and it keeps a one-deep output stage. The model is compared with the ports on every falling edge, so each result is sampled exactly in the cycle it is due.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

    localparam int DEF_PIX_W     = 8;
    localparam int DEF_LINE_LEN  = 576;
    localparam int DEF_SRC_LINES = 378;
    localparam int DEF_DST_LINES = 600;
    localparam int DEF_FRAC_W    = 8;

    // Fixed-point vertical step per output line, in source-line units
    function automatic int step_fix(input int src, input int dst, input int fw);
        return (src << fw) / dst;
    endfunction

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_sel_e;

endpackage

// File: rtl/line_bank.sv
module line_bank #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 576,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PIX_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PIX_W-1:0] rdata
);
    logic [PIX_W-1:0] mem [DEPTH];

    // Read-before-write: a read on the write address returns the old word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vpos_accum.sv
module vpos_accum #(
    parameter int LW     = 9,
    parameter int FRAC_W = 8,
    parameter int POS_W  = 18,
    parameter int STEP   = 161,
    parameter int LAST   = 377
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_adv,
    output logic [POS_W-1:0]  pos,
    output logic [LW-1:0]     upper,
    output logic [FRAC_W-1:0] frac,
    output logic              same_line
);
    localparam int UW = POS_W - FRAC_W;

    logic [POS_W:0]  nxt_sum;
    logic [UW-1:0]   upper_raw;

    assign nxt_sum = {1'b0, pos} + (POS_W+1)'(STEP);

    // Saturating advance: the position never wraps within a frame
    always_ff @(posedge clk) begin
        if (rst || frame_start)
            pos <= '0;
        else if (line_adv && !nxt_sum[POS_W])
            pos <= nxt_sum[POS_W-1:0];
    end

    assign upper_raw = pos[POS_W-1:FRAC_W];
    assign frac      = pos[FRAC_W-1:0];

    always_comb begin
        if (upper_raw >= UW'(LAST)) begin
            upper     = LW'(LAST);
            same_line = 1'b1;
        end else begin
            upper     = upper_raw[LW-1:0];
            same_line = 1'b0;
        end
    end
endmodule

// File: rtl/blend_unit.sv
module blend_unit #(
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic [PIX_W-1:0]  even_pix,
    input  logic [PIX_W-1:0]  odd_pix,
    input  logic [FRAC_W-1:0] frac,
    input  logic              upper_odd,
    input  logic              same_line,
    output logic [PIX_W-1:0]  result
);
    localparam int PROD_W = PIX_W + FRAC_W;
    localparam int SUM_W  = PROD_W + 1;

    logic [PIX_W-1:0]  ch_even, ch_odd;
    logic [FRAC_W-1:0] w_even, w_odd;
    logic [PROD_W-1:0] prod_even, prod_odd;
    logic [SUM_W-1:0]  sum;
    logic [PIX_W:0]    shifted;

    always_comb begin
        // Upper neighbour's bank gets the inverted fraction
        w_even = upper_odd ? frac : ~frac;
        w_odd  = upper_odd ? ~frac : frac;
        if (same_line) begin
            ch_even = upper_odd ? odd_pix : even_pix;
            ch_odd  = upper_odd ? odd_pix : even_pix;
        end else begin
            ch_even = even_pix;
            ch_odd  = odd_pix;
        end
        prod_even = PROD_W'(ch_even) * PROD_W'(w_even);
        prod_odd  = PROD_W'(ch_odd)  * PROD_W'(w_odd);
        sum       = SUM_W'(prod_even) + SUM_W'(prod_odd);
        shifted   = sum[SUM_W-1:FRAC_W];
        result    = shifted[PIX_W] ? '1 : shifted[PIX_W-1:0];
    end
endmodule

// File: rtl/vlin_scaler.sv
module vlin_scaler
    import vscale_pkg::*;
#(
    parameter int PIX_W     = DEF_PIX_W,
    parameter int LINE_LEN  = DEF_LINE_LEN,
    parameter int SRC_LINES = DEF_SRC_LINES,
    parameter int DST_LINES = DEF_DST_LINES,
    parameter int FRAC_W    = DEF_FRAC_W,
    localparam int XW       = $clog2(LINE_LEN),
    localparam int LW       = $clog2(SRC_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic [XW-1:0]    wr_x,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             frame_start,
    input  logic             line_adv,
    input  logic             rd_en,
    input  logic [XW-1:0]    rd_x,
    output logic             pix_valid,
    output logic [PIX_W-1:0] pix_data,
    output logic [LW-1:0]    pix_upper
);
    localparam int POS_W = LW + FRAC_W + 1;
    localparam int STEP  = step_fix(SRC_LINES, DST_LINES, FRAC_W);
    localparam int LAST  = SRC_LINES - 1;

    typedef struct packed {
        logic              vld;
        logic [LW-1:0]     upper;
        logic [FRAC_W-1:0] frac;
        logic              same;
    } stage_t;

    logic [PIX_W-1:0]  bank_q [2];
    logic [POS_W-1:0]  acc_pos;
    logic [LW-1:0]     cur_upper;
    logic [FRAC_W-1:0] cur_frac;
    logic              cur_same;
    stage_t            s1;
    logic [PIX_W-1:0]  blend_out;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        line_bank #(.PIX_W(PIX_W), .DEPTH(LINE_LEN), .AW(XW)) u_bank (
            .clk   (clk),
            .we    (wr_en && (wr_line[0] == bank_sel_e'(b))),
            .waddr (wr_x),
            .wdata (wr_data),
            .raddr (rd_x),
            .rdata (bank_q[b])
        );
    end

    vpos_accum #(.LW(LW), .FRAC_W(FRAC_W), .POS_W(POS_W), .STEP(STEP), .LAST(LAST)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_adv    (line_adv),
        .pos         (acc_pos),
        .upper       (cur_upper),
        .frac        (cur_frac),
        .same_line   (cur_same)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld   <= rd_en;
            s1.upper <= cur_upper;
            s1.frac  <= cur_frac;
            s1.same  <= cur_same;
        end
    end

    blend_unit #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_blend (
        .even_pix  (bank_q[BANK_EVEN]),
        .odd_pix   (bank_q[BANK_ODD]),
        .frac      (s1.frac),
        .upper_odd (s1.upper[0]),
        .same_line (s1.same),
        .result    (blend_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_upper <= '0;
        end else begin
            pix_valid <= s1.vld;
            pix_data  <= blend_out;
            pix_upper <= s1.upper;
        end
    end
endmodule

// File: rtl/vlin_scaler_chk.sv
module vlin_scaler_chk #(
    parameter int LW        = 9,
    parameter int POS_W     = 18,
    parameter int SRC_LINES = 378
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             line_adv,
    input logic             rd_en,
    input logic             pix_valid,
    input logic [LW-1:0]    pix_upper,
    input logic [POS_W-1:0] pos
);
    // R3: frame start clears the position
    a_r3_frame_clear: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos == '0));

    // R3: no pulse, no movement
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !line_adv) |=> $stable(pos));

    // R3: an advance never moves backwards
    a_r3_forward: assert property (@(posedge clk) disable iff (rst)
        (line_adv && !frame_start) |=> (pos >= $past(pos)));

    // R7: each request is answered two edges later
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> ##2 pix_valid);

    // R7: no request, no output
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> ##2 !pix_valid);

    // R6: reported upper line never lies past the frame
    a_r6_in_frame: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_upper <= LW'(SRC_LINES - 1)));
endmodule

bind vlin_scaler vlin_scaler_chk #(.LW(LW), .POS_W(POS_W), .SRC_LINES(SRC_LINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .line_adv    (line_adv),
    .rd_en       (rd_en),
    .pix_valid   (pix_valid),
    .pix_upper   (pix_upper),
    .pos         (acc_pos)
);

// File: tb/vlin_scaler_bench.sv
module vlin_scaler_bench;
    localparam int NPIX  = 576;
    localparam int LASTL = 377;
    localparam int STEP  = (378 * 256) / 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_line = '0;
    logic [9:0] wr_x = '0;
    logic [7:0] wr_data = '0;
    logic       frame_start = 1'b0;
    logic       line_adv = 1'b0;
    logic       rd_en = 1'b0;
    logic [9:0] rd_x = '0;
    logic       pix_valid;
    logic [7:0] pix_data;
    logic [8:0] pix_upper;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    vlin_scaler u_vlin_scaler (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_line(wr_line), .wr_x(wr_x),
        .wr_data(wr_data), .frame_start(frame_start), .line_adv(line_adv),
        .rd_en(rd_en), .rd_x(rd_x), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_upper(pix_upper)
    );

    // Behavioural reference model
    int ev [NPIX];
    int od [NPIX];
    int pos = 0;
    int s1_v = 0, s1_d = 0, s1_u = 0;
    int o_v = 0, o_d = 0, o_u = 0;

    always @(posedge clk) begin
        if (rst) begin
            pos = 0; s1_v = 0; o_v = 0;
        end else begin
            int u, f, p;
            o_v = s1_v; o_d = s1_d; o_u = s1_u;
            s1_v = rd_en;
            if (rd_en) begin
                u = pos / 256;
                f = pos % 256;
                if (u >= LASTL) begin
                    u = LASTL;                                   // R6
                    p = (u % 2 == 1) ? od[rd_x] : ev[rd_x];
                    s1_d = (p * 255) / 256;
                end else if (u % 2 == 0) begin
                    s1_d = (ev[rd_x] * (255 - f) + od[rd_x] * f) / 256;   // R5
                end else begin
                    s1_d = (od[rd_x] * (255 - f) + ev[rd_x] * f) / 256;   // R5 swap
                end
                if (s1_d > 255) s1_d = 255;
                s1_u = u;
            end
            if (wr_en) begin                                     // R2
                if (wr_line[0]) od[wr_x] = wr_data;
                else            ev[wr_x] = wr_data;
            end
            if (frame_start)   pos = 0;                          // R3
            else if (line_adv) pos = pos + STEP;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (pix_valid !== (o_v != 0)) begin
                fails++;
                $display("FAIL R7 pix_valid actual=%0b expected=%0d", pix_valid, o_v);
            end
            if (o_v != 0) begin
                tests++;
                if (pix_data !== 8'(o_d)) begin
                    fails++;
                    if (o_u == LASTL)
                        $display("FAIL R6 pix_data actual=%0d expected=%0d", pix_data, o_d);
                    else
                        $display("FAIL R5 pix_data actual=%0d expected=%0d", pix_data, o_d);
                end
                tests++;
                if (pix_upper !== 9'(o_u)) begin
                    fails++;
                    $display("FAIL R4 pix_upper actual=%0d expected=%0d", pix_upper, o_u);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr_px(input int line, input int x, input int d);
        wr_en = 1'b1; wr_line = 9'(line); wr_x = 10'(x); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_px(input int x);
        rd_en = 1'b1; rd_x = 10'(x);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            line_adv = 1'b1;
            @(negedge clk);
        end
        line_adv = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NPIX; i++) begin ev[i] = 0; od[i] = 0; end
        idle(3);
        rst = 1'b0;
        // R1: output idle right after reset
        tests++;
        if (pix_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 pix_valid actual=%0b expected=0", pix_valid);
        end

        // R2: even line 0 into even bank, odd line 1 into odd bank
        for (int x = 0; x < NPIX; x++) wr_px(0, x, x & 255);
        for (int x = 0; x < NPIX; x++) wr_px(1, x, (x * 37 + 11) & 255);

        // R3/R5: position 0, fraction 0, even upper
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        for (int x = 0; x < 20; x++) rd_px(x);
        idle(2);

        // R3/R7: one step, fraction 161, requests with gaps
        adv(1);
        for (int x = 100; x < 130; x += 3) begin rd_px(x); idle(x % 2); end
        rd_px(575);
        idle(2);

        // R5 swap: upper line 1 (odd), even bank reloaded with line 2
        adv(1);
        for (int x = 0; x < NPIX; x++) wr_px(2, x, (x ^ 8'h5A) & 255);
        for (int x = 200; x < 240; x += 5) rd_px(x);
        // R2: read and write same column in one cycle returns old content
        wr_en = 1'b1; wr_line = 9'd2; wr_x = 10'd300; wr_data = 8'hFF;
        rd_en = 1'b1; rd_x = 10'd300;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        rd_px(300);
        idle(2);

        // Near the end of the frame: upper 376 (even)
        adv(597);
        for (int x = 10; x < 20; x++) rd_px(x);
        // R6: upper reaches the last line
        adv(2);
        for (int x = 30; x < 40; x++) rd_px(x);
        // R6: past the last line, still clamped
        adv(5);
        for (int x = 40; x < 45; x++) rd_px(x);
        idle(2);

        // R3: frame_start wins over line_adv
        frame_start = 1'b1; line_adv = 1'b1; @(negedge clk);
        frame_start = 1'b0; line_adv = 1'b0;
        for (int x = 50; x < 55; x++) rd_px(x);
        idle(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule